// File: doc/BRIEF.md
# Windowed Data Address Translator

This block turns a 16-bit data address into a physical target: a region select, a byte offset inside that region and a bus-fault flag. The lower half of the address space reaches internal data RAM unchanged. The top quarter is an I/O region. Only one 16-byte slot in that region is allowed, and every other address there faults.

The quarter between them is a 16 KB window. A 16-bit map register steers that window. One bit of the register picks the target. The target is either a 16 KB page of instruction memory, or a 16 KB page inside one 128 KB segment of unified memory. A 128-bit presence vector says which unified segments exist. A window access to a missing segment faults.

The map register is the only storage. It is loaded through a single write-enable port, and everything else is combinational.

Top module: `win_xlate`

## Requirements
- R1: After reset the map register holds 0, so a window access goes to unified segment 0, page 0.
- R2: Addresses 0x0000 to 0x7FFF select region data (code 0). The offset equals the address, the segment output is 0 and there is no fault.
- R3: Addresses 0xC000 to 0xFFFF select region data (code 0) with offset equal to the address. The fault flag is raised unless address bits 15:4 equal 0xFF0.
- R4: Addresses 0xFF00 to 0xFF0F do not fault.
- R5: For addresses 0x8000 to 0xBFFF with map bit 12 set, the region is instruction memory (code 1). The offset is map bits 3:0 times 0x4000 plus address bits 13:0, the segment output is 0 and there is no fault.
- R6: For addresses 0x8000 to 0xBFFF with map bit 12 clear, the region is unified memory (code 2). The segment is map bits 9:3, and the offset is map bits 2:0 times 0x4000 plus address bits 13:0.
- R7: A unified access faults exactly when the presence bit of the selected segment is 0.
- R8: A write with the enable high loads the map register at the clock edge, and translation uses the new value from then on. While the enable is low, the register keeps its value whatever the data input carries.
- R9: Map bits 15:13 and 11:10 have no effect on translation. In instruction mode, bits 9:4 have no effect either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| map_we | input | 1 | Map register write enable |
| map_wdata | input | 16 | Map register write data |
| seg_present | input | 128 | One bit per unified segment, 1 = populated |
| addr | input | 16 | Data address to translate |
| region | output | 2 | 0 data RAM, 1 instruction memory, 2 unified memory |
| phys_off | output | 18 | Byte offset inside the selected region or segment |
| seg_sel | output | 7 | Unified segment number (0 for other regions) |
| fault | output | 1 | Bus fault |

## Verification
The hardest case to reach from the ports is a fault on a segment that is missing. It needs three things at once: the map register pointing at the far end of the segment range, the select bit clear, and a presence vector with that one bit dropped.

The bench first loads a map value with every don't-care bit set alongside the top segment and page numbers. It then clears only the matching presence bit. Next to that, it checks the reset-time mapping with segment 0 removed. It also confirms that a map write with the enable low changes nothing.

// File: rtl/win_xlate.sv
module win_xlate #(
  parameter int ADDR_W  = 16,
  parameter int PAGE_W  = 14,
  parameter int SEG_CNT = 128,
  parameter int IPAGE_W = 4,
  parameter int UPAGE_W = 3,
  parameter int SEL_BIT = 12
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                map_we,
  input  logic [ADDR_W-1:0]                   map_wdata,
  input  logic [SEG_CNT-1:0]                  seg_present,
  input  logic [ADDR_W-1:0]                   addr,
  output logic [1:0]                          region,
  output logic [PAGE_W+IPAGE_W-1:0]           phys_off,
  output logic [$clog2(SEG_CNT)-1:0]          seg_sel,
  output logic                                fault
);
  localparam int SEG_W = $clog2(SEG_CNT);
  localparam int OFF_W = PAGE_W + IPAGE_W;
  localparam logic [1:0] RG_DATA = 2'd0;
  localparam logic [1:0] RG_INST = 2'd1;
  localparam logic [1:0] RG_UNI  = 2'd2;
  localparam logic [ADDR_W-5:0] IO_SLOT = 12'hFF0;

  logic [ADDR_W-1:0] map_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      map_q <= '0;
    else if (map_we) map_q <= map_wdata;

  wire [1:0] quad   = addr[ADDR_W-1:ADDR_W-2];
  wire in_win       = (quad == 2'b10);
  wire in_io        = (quad == 2'b11);
  wire io_ok        = (addr[ADDR_W-1:4] == IO_SLOT);
  wire to_inst      = map_q[SEL_BIT];
  wire [SEG_W-1:0] useg = map_q[UPAGE_W +: SEG_W];
  wire [PAGE_W-1:0] low = addr[PAGE_W-1:0];

  wire [OFF_W-1:0] inst_off = {map_q[IPAGE_W-1:0], low};
  wire [OFF_W-1:0] uni_off  = OFF_W'({map_q[UPAGE_W-1:0], low});

  always_comb begin
    region   = RG_DATA;
    phys_off = OFF_W'(addr);
    seg_sel  = '0;
    fault    = 1'b0;
    if (in_win) begin
      if (to_inst) begin
        region   = RG_INST;
        phys_off = inst_off;
      end else begin
        region   = RG_UNI;
        phys_off = uni_off;
        seg_sel  = useg;
        fault    = !seg_present[useg];
      end
    end else if (in_io) begin
      fault = !io_ok;
    end
  end

  a_r2_low_direct: assert property (@(posedge clk) disable iff (!rst_n)
    !addr[ADDR_W-1] |-> (region == RG_DATA && !fault && phys_off == OFF_W'(addr)));
  a_r3_io_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (in_io && !io_ok) |-> fault);
  a_r4_io_slot: assert property (@(posedge clk) disable iff (!rst_n)
    io_ok |-> !fault);
  a_r7_missing_seg: assert property (@(posedge clk) disable iff (!rst_n)
    (region == RG_UNI && !seg_present[seg_sel]) |-> fault);
  a_r8_map_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !map_we |=> $stable(map_q));
endmodule

// File: tb/test_win_xlate.sv
module test_win_xlate;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic map_we = 1'b0;
  logic [15:0] map_wdata = '0;
  logic [127:0] seg_present = '1;
  logic [15:0] addr = '0;
  logic [1:0] region;
  logic [17:0] phys_off;
  logic [6:0] seg_sel;
  logic fault;

  typedef struct packed {
    logic [1:0]  rg;
    logic [17:0] off;
    logic [6:0]  seg;
    logic        flt;
    logic [3:0]  req;
  } exp_t;

  exp_t q[$];
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  win_xlate i_win_xlate (
    .clk(clk), .rst_n(rst_n), .map_we(map_we), .map_wdata(map_wdata),
    .seg_present(seg_present), .addr(addr), .region(region),
    .phys_off(phys_off), .seg_sel(seg_sel), .fault(fault)
  );

  task automatic drive(input logic [15:0] a, input logic [1:0] rg,
                       input logic [17:0] off, input logic [6:0] seg,
                       input logic flt, input logic [3:0] req);
    exp_t e;
    @(negedge clk);
    addr = a;
    #1;
    e.rg = rg; e.off = off; e.seg = seg; e.flt = flt; e.req = req;
    q.push_back(e);
    #1;
  endtask

  task automatic write_map(input logic [15:0] v, input logic en);
    @(negedge clk);
    map_we = en;
    map_wdata = v;
    @(negedge clk);
    map_we = 1'b0;
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      wait (q.size() > 0);
      e = q.pop_front();
      n_chk++;
      if (region !== e.rg || phys_off !== e.off || seg_sel !== e.seg || fault !== e.flt) begin
        n_bad++;
        $display("FAIL R%0d addr=%h got rg=%0d off=%h seg=%h flt=%b exp rg=%0d off=%h seg=%h flt=%b",
                 e.req, addr, region, phys_off, seg_sel, fault, e.rg, e.off, e.seg, e.flt);
      end
    end
  end

  initial begin : watchdog
    #800000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset map = 0 -> unified segment 0, page 0
    drive(16'h8123, 2'd2, 18'h00123, 7'd0, 1'b0, 4'd1);
    seg_present[0] = 1'b0;
    // R7 with reset mapping
    drive(16'h8123, 2'd2, 18'h00123, 7'd0, 1'b1, 4'd7);
    seg_present[0] = 1'b1;
    // R2 low half
    drive(16'h0000, 2'd0, 18'h00000, 7'd0, 1'b0, 4'd2);
    drive(16'h7FFF, 2'd0, 18'h07FFF, 7'd0, 1'b0, 4'd2);
    // R3 / R4 I/O region
    drive(16'hC000, 2'd0, 18'h0C000, 7'd0, 1'b1, 4'd3);
    drive(16'hFEFF, 2'd0, 18'h0FEFF, 7'd0, 1'b1, 4'd3);
    drive(16'hFF10, 2'd0, 18'h0FF10, 7'd0, 1'b1, 4'd3);
    drive(16'hFFFF, 2'd0, 18'h0FFFF, 7'd0, 1'b1, 4'd3);
    drive(16'hFF00, 2'd0, 18'h0FF00, 7'd0, 1'b0, 4'd4);
    drive(16'hFF0F, 2'd0, 18'h0FF0F, 7'd0, 1'b0, 4'd4);
    // R5 instruction window, page 5
    write_map(16'h1005, 1'b1);
    drive(16'hBFFF, 2'd1, 18'h17FFF, 7'd0, 1'b0, 4'd5);
    drive(16'h8000, 2'd1, 18'h14000, 7'd0, 1'b0, 4'd5);
    // R9: bits 15:13, 11:10, 9:4 ignored in instruction mode -> page 2
    write_map(16'hFCF2, 1'b1);
    drive(16'h8001, 2'd1, 18'h08001, 7'd0, 1'b0, 4'd9);
    // R6 unified: map 0x0015 -> seg 2, page 5
    write_map(16'h0015, 1'b1);
    drive(16'hA000, 2'd2, 18'h16000, 7'd2, 1'b0, 4'd6);
    // R8 hold while enable low
    write_map(16'h1000, 1'b0);
    drive(16'hA000, 2'd2, 18'h16000, 7'd2, 1'b0, 4'd8);
    // R9 + R6: upper bits set, seg 127, page 7
    write_map(16'hEFFF, 1'b1);
    drive(16'h8001, 2'd2, 18'h1C001, 7'd127, 1'b0, 4'd9);
    // R7 missing top segment
    seg_present[127] = 1'b0;
    drive(16'h8001, 2'd2, 18'h1C001, 7'd127, 1'b1, 4'd7);
    seg_present[127] = 1'b1;
    // R8 new value takes effect after the write edge
    write_map(16'h1003, 1'b1);
    drive(16'h9234, 2'd1, 18'h0D234, 7'd0, 1'b0, 4'd8);
    wait (q.size() == 0);
    #2;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule